// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block turns eight already-synchronised input pins into eight interrupt request lines. Each channel is either edge-sensitive or level-sensitive. An edge channel keeps two sticky flags, one for rising transitions and one for falling transitions. A flag raises a request only when the matching enable is set. A level channel raises a request while its pin equals a programmable active level, and it stores nothing.

A small word-addressed register port configures the block and observes it. Writes take effect on the clock edge, and reads are combinational from the address. The status register has a side effect on writes that depends on the channel's mode. On an edge channel, writing 1 clears both sticky flags. On a level channel, writing 1 inverts the active level. A control bit can hand the request lines over to an externally computed pattern-match vector. A second control bit stores the enable for a processor wake event.

Register offsets on `addr` are as follows. In every register, bit n belongs to channel n.

| Offset | Register | Meaning of a 1 in bit n |
|---|---|---|
| 0 | mode | channel n is level-sensitive (0 means edge-sensitive) |
| 1 | rise/level enable | enables rising-edge requests, or enables the level request |
| 2 | fall enable | enables falling-edge requests |
| 3 | active level | level channel n is active high (0 means active low) |
| 4 | rise flags | reads the flag; writing 1 clears it |
| 5 | fall flags | reads the flag; writing 1 clears it |
| 6 | status | reads the request; writing 1 triggers the mode-dependent side effect |
| 7 | control | bit 0 selects the pattern-match vector; bit 1 enables the wake event |

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset, every register reads 0, every flag is 0 and `irq_o` is 0.
- R2: Registers 0 to 6 hold bits 7:0, one bit per channel. Register 7 holds bits 1:0. All higher read-data bits read 0, even after a write of all ones.
- R3: An edge is found by comparing each pin with its value on the previous clock. Edges are recorded in the flag registers (offsets 4 and 5) whether or not they are enabled. The first clock after reset records no edge.
- R4: Writing 1 to a bit of offset 4 or 5 clears that flag. Writing 0 leaves the flag unchanged.
- R5: For an edge channel, the request is (rise flag AND rise enable) OR (fall flag AND fall enable).
- R6: For a level channel, the request is the rise/level enable AND (pin equals the active-level bit). The request follows the pin in the same cycle and is never latched.
- R7: A read of offset 6 returns the per-channel request, whatever the control bits are.
- R8: Writing 1 to a bit of offset 6 for an edge channel clears both its rise flag and its fall flag.
- R9: Writing 1 to a bit of offset 6 for a level channel inverts its active-level bit (offset 3).
- R10: An edge that arrives in the same cycle as a clear of its flag wins, so the flag stays 1.
- R11: When control bit 0 is 1, `irq_o` equals `pm_i`. When it is 0, `irq_o` equals the pin requests. Control bit 1 reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 8 | Synchronised channel pins |
| pm_i | input | 8 | External pattern-match result vector |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_o | output | 8 | Interrupt request lines |

## Verification
The assertions check these properties on every cycle:
- a detected edge is always present in its flag on the following cycle, even when a clear arrives in the same cycle;
- a flag never rises without a detected edge;
- a non-edge clear really empties its flag;
- a status write inverts exactly the active levels of the level channels;
- the request lines follow either the pattern vector or the level equation;
- the reserved read bits stay at zero.

Some behaviours can only be shown by the bench's scenarios against its reference model:
- the absence of a spurious edge when the pins are high through reset;
- combined edge and level traffic under random register writes;
- a status read that keeps reporting pin requests while the lines carry the pattern vector.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int unsigned RA_W = 3;

  typedef enum logic [RA_W-1:0] {
    OFS_MODE  = 3'd0,
    OFS_ENR   = 3'd1,
    OFS_ENF   = 3'd2,
    OFS_LVL   = 3'd3,
    OFS_RISE  = 3'd4,
    OFS_FALL  = 3'd5,
    OFS_STAT  = 3'd6,
    OFS_CTRL  = 3'd7
  } reg_ofs_e;

  typedef struct packed {
    logic ev_en;
    logic sel_pm;
  } ctrl_t;

  // sticky flag update: a new edge outranks a clear
  function automatic logic flag_next(logic cur, logic clr, logic ev);
    return (cur & ~clr) | ev;
  endfunction

  function automatic logic edge_req(logic rf, logic enr, logic ff, logic enf);
    return (rf & enr) | (ff & enf);
  endfunction

  function automatic logic level_req(logic en, logic pin, logic act);
    return en & ~(pin ^ act);
  endfunction
endpackage

// File: rtl/pinirq_edge.sv
module pinirq_edge #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  input  logic [N-1:0] clr_rise,
  input  logic [N-1:0] clr_fall,
  output logic [N-1:0] rise_ev,
  output logic [N-1:0] fall_ev,
  output logic [N-1:0] rise_flag,
  output logic [N-1:0] fall_flag
);
  import pinirq_pkg::*;

  logic [N-1:0] prev_q;
  logic         seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= pins_i;
      seen_q <= 1'b1;
    end
  end

  assign rise_ev = seen_q ? (pins_i & ~prev_q) : '0;
  assign fall_ev = seen_q ? (~pins_i & prev_q) : '0;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_flag[i] <= 1'b0;
        fall_flag[i] <= 1'b0;
      end else begin
        rise_flag[i] <= flag_next(rise_flag[i], clr_rise[i], rise_ev[i]);
        fall_flag[i] <= flag_next(fall_flag[i], clr_fall[i], fall_ev[i]);
      end
    end
  end
endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [pinirq_pkg::RA_W-1:0] addr,
  input  logic [DW-1:0]               wdata,
  input  logic [N-1:0]                rise_flag,
  input  logic [N-1:0]                fall_flag,
  input  logic [N-1:0]                req,
  output logic [N-1:0]                mode,
  output logic [N-1:0]                enr,
  output logic [N-1:0]                enf,
  output logic [N-1:0]                lvl,
  output logic                        sel_pm,
  output logic [N-1:0]                clr_rise,
  output logic [N-1:0]                clr_fall,
  output logic [DW-1:0]               rdata
);
  import pinirq_pkg::*;

  localparam int unsigned PAD = DW - N;

  ctrl_t        ctrl_q;
  logic [N-1:0] wbits;
  logic         wr_mode, wr_enr, wr_enf, wr_lvl, wr_rise, wr_fall, wr_stat, wr_ctrl;
  logic [N-1:0] lvl_flip;

  assign wbits   = wdata[N-1:0];
  assign wr_mode = wr_en && (reg_ofs_e'(addr) == OFS_MODE);
  assign wr_enr  = wr_en && (reg_ofs_e'(addr) == OFS_ENR);
  assign wr_enf  = wr_en && (reg_ofs_e'(addr) == OFS_ENF);
  assign wr_lvl  = wr_en && (reg_ofs_e'(addr) == OFS_LVL);
  assign wr_rise = wr_en && (reg_ofs_e'(addr) == OFS_RISE);
  assign wr_fall = wr_en && (reg_ofs_e'(addr) == OFS_FALL);
  assign wr_stat = wr_en && (reg_ofs_e'(addr) == OFS_STAT);
  assign wr_ctrl = wr_en && (reg_ofs_e'(addr) == OFS_CTRL);

  // status writes: clear on edge channels, invert polarity on level channels
  assign clr_rise = (wr_rise ? wbits : '0) | (wr_stat ? (wbits & ~mode) : '0);
  assign clr_fall = (wr_fall ? wbits : '0) | (wr_stat ? (wbits & ~mode) : '0);
  assign lvl_flip = wr_stat ? (wbits & mode) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      enr    <= '0;
      enf    <= '0;
      lvl    <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_mode) mode <= wbits;
      if (wr_enr)  enr  <= wbits;
      if (wr_enf)  enf  <= wbits;
      if (wr_lvl)  lvl  <= wbits;
      else         lvl  <= lvl ^ lvl_flip;
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[1:0]);
    end
  end

  assign sel_pm = ctrl_q.sel_pm;

  always_comb begin
    rdata = '0;
    unique case (reg_ofs_e'(addr))
      OFS_MODE: rdata = {{PAD{1'b0}}, mode};
      OFS_ENR:  rdata = {{PAD{1'b0}}, enr};
      OFS_ENF:  rdata = {{PAD{1'b0}}, enf};
      OFS_LVL:  rdata = {{PAD{1'b0}}, lvl};
      OFS_RISE: rdata = {{PAD{1'b0}}, rise_flag};
      OFS_FALL: rdata = {{PAD{1'b0}}, fall_flag};
      OFS_STAT: rdata = {{PAD{1'b0}}, req};
      OFS_CTRL: rdata = {{(DW-2){1'b0}}, ctrl_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/pinirq_req.sv
module pinirq_req #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] pins_i,
  input  logic [N-1:0] pm_i,
  input  logic [N-1:0] mode,
  input  logic [N-1:0] enr,
  input  logic [N-1:0] enf,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] rise_flag,
  input  logic [N-1:0] fall_flag,
  input  logic         sel_pm,
  output logic [N-1:0] req,
  output logic [N-1:0] irq_o
);
  import pinirq_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_ch
    assign req[i] = mode[i] ? level_req(enr[i], pins_i[i], lvl[i])
                            : edge_req(rise_flag[i], enr[i], fall_flag[i], enf[i]);
  end

  assign irq_o = sel_pm ? pm_i : req;
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                pins_i,
  input  logic [N-1:0]                pm_i,
  input  logic                        wr_en,
  input  logic [pinirq_pkg::RA_W-1:0] addr,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rdata,
  output logic [N-1:0]                irq_o
);
  logic [N-1:0] rise_ev, fall_ev, rise_flag, fall_flag;
  logic [N-1:0] clr_rise, clr_fall;
  logic [N-1:0] mode, enr, enf, lvl, req;
  logic         sel_pm;

  pinirq_edge #(.N(N)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_i    (pins_i),
    .clr_rise  (clr_rise),
    .clr_fall  (clr_fall),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev),
    .rise_flag (rise_flag),
    .fall_flag (fall_flag)
  );

  pinirq_regs #(.N(N), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rise_flag (rise_flag),
    .fall_flag (fall_flag),
    .req       (req),
    .mode      (mode),
    .enr       (enr),
    .enf       (enf),
    .lvl       (lvl),
    .sel_pm    (sel_pm),
    .clr_rise  (clr_rise),
    .clr_fall  (clr_fall),
    .rdata     (rdata)
  );

  pinirq_req #(.N(N)) u_req (
    .pins_i    (pins_i),
    .pm_i      (pm_i),
    .mode      (mode),
    .enr       (enr),
    .enf       (enf),
    .lvl       (lvl),
    .rise_flag (rise_flag),
    .fall_flag (fall_flag),
    .sel_pm    (sel_pm),
    .req       (req),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/pinirq_chk.sv
module pinirq_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N-1:0]                pins_i,
  input logic [N-1:0]                pm_i,
  input logic                        wr_en,
  input logic [pinirq_pkg::RA_W-1:0] addr,
  input logic [DW-1:0]               wdata,
  input logic [DW-1:0]               rdata,
  input logic [N-1:0]                irq_o,
  input logic [N-1:0]                mode,
  input logic [N-1:0]                enr,
  input logic [N-1:0]                lvl,
  input logic                        sel_pm,
  input logic [N-1:0]                rise_ev,
  input logic [N-1:0]                fall_ev,
  input logic [N-1:0]                rise_flag,
  input logic [N-1:0]                fall_flag,
  input logic [N-1:0]                clr_rise,
  input logic [N-1:0]                clr_fall
);
  logic stat_wr, lvl_wr;
  assign stat_wr = wr_en && (addr == 3'd6);
  assign lvl_wr  = wr_en && (addr == 3'd3);

  // R10
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev != '0) |=> ((rise_flag & $past(rise_ev)) == $past(rise_ev)));

  // R10
  fall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev != '0) |=> ((fall_flag & $past(fall_ev)) == $past(fall_ev)));

  // R3
  flag_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_flag & ~$past(rise_flag) & ~$past(rise_ev)) == '0) &&
    ((fall_flag & ~$past(fall_flag) & ~$past(fall_ev)) == '0));

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_fall & ~fall_ev) != '0) |=> ((fall_flag & $past(clr_fall & ~fall_ev)) == '0));

  // R9
  lvl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !lvl_wr) |=> (lvl == ($past(lvl) ^ ($past(wdata[N-1:0]) & $past(mode)))));

  // R11
  pm_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pm |-> (irq_o == pm_i));

  // R6
  level_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_pm |-> ((irq_o & mode) == (enr & mode & ~(pins_i ^ lvl))));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:N] == '0);
endmodule

bind pinirq_ctrl pinirq_chk #(.N(N), .DW(DW)) u_chk (.*);

// File: tb/sim_pinirq_ctrl.sv
module sim_pinirq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pins_i, pm_i;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic [7:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_mode, m_enr, m_enf, m_lvl, m_rf, m_ff, m_prev;
  logic [1:0] m_ctrl;
  bit         m_seen;

  pinirq_ctrl u0 (.clk(clk), .rst_n(rst_n), .pins_i(pins_i), .pm_i(pm_i),
                  .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_req();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (m_mode[i]) r[i] = m_enr[i] && (pins_i[i] == m_lvl[i]);
      else           r[i] = (m_rf[i] && m_enr[i]) || (m_ff[i] && m_enf[i]);
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_irq();
    return m_ctrl[0] ? pm_i : exp_req();
  endfunction

  function automatic logic [31:0] exp_reg(input logic [2:0] a);
    case (a)
      3'd0: return {24'd0, m_mode};
      3'd1: return {24'd0, m_enr};
      3'd2: return {24'd0, m_enf};
      3'd3: return {24'd0, m_lvl};
      3'd4: return {24'd0, m_rf};
      3'd5: return {24'd0, m_ff};
      3'd6: return {24'd0, exp_req()};
      default: return {30'd0, m_ctrl};
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model update at a clock edge from the inputs that are being applied
  task automatic model_edge();
    logic [7:0] rev, fev, crise, cfall, w;
    rev = m_seen ? (pins_i & ~m_prev) : 8'd0;
    fev = m_seen ? (~pins_i & m_prev) : 8'd0;
    w = wdata[7:0];
    crise = 8'd0; cfall = 8'd0;
    if (wr_en) begin
      case (addr)
        3'd0: m_mode = w;
        3'd1: m_enr = w;
        3'd2: m_enf = w;
        3'd3: m_lvl = w;
        3'd4: crise = w;
        3'd5: cfall = w;
        3'd6: begin
          crise = w & ~m_mode;
          cfall = w & ~m_mode;
          m_lvl = m_lvl ^ (w & m_mode);
        end
        default: m_ctrl = wdata[1:0];
      endcase
    end
    m_rf = (m_rf & ~crise) | rev;
    m_ff = (m_ff & ~cfall) | fev;
    m_prev = pins_i;
    m_seen = 1'b1;
  endtask

  task automatic cyc(input logic [7:0] p, input logic [7:0] pm, input logic we,
                     input logic [2:0] a, input logic [31:0] d);
    pins_i = p; pm_i = pm; wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en = 1'b0;
    check({24'd0, irq_o}, {24'd0, exp_irq()}, "R5/R6/R11 irq");
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    wr_en = 1'b0; addr = a;
    #1;
    check(rdata, exp_reg(a), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; pins_i = 8'hFF; pm_i = 8'h00; wr_en = 1'b0; addr = 3'd0; wdata = '0;
    m_mode = 0; m_enr = 0; m_enf = 0; m_lvl = 0; m_rf = 0; m_ff = 0; m_prev = 0;
    m_ctrl = 0; m_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset value");
    check({24'd0, irq_o}, 32'd0, "R1 irq after reset");

    // R3: pins high through reset, first clock must not make an edge
    cyc(8'hFF, 8'h00, 1'b0, 3'd0, 0);
    rd(3'd4, "R3 no spurious rise");
    rd(3'd5, "R3 no spurious fall");

    // R2: reserved bits
    cyc(8'hFF, 8'h00, 1'b1, 3'd0, 32'hFFFF_FF0F);
    rd(3'd0, "R2 reserved zero");
    cyc(8'hFF, 8'h00, 1'b1, 3'd0, 32'h0000_0000);

    // R3: edges recorded while disabled
    cyc(8'h0F, 8'h00, 1'b0, 3'd0, 0);
    rd(3'd5, "R3 fall recorded disabled");
    check({24'd0, irq_o}, 32'd0, "R3 disabled no irq");
    cyc(8'hFF, 8'h00, 1'b0, 3'd0, 0);
    rd(3'd4, "R3 rise recorded disabled");

    // R5: enable edges
    cyc(8'hFF, 8'h00, 1'b1, 3'd1, 32'h0000_00F0);
    cyc(8'hFF, 8'h00, 1'b1, 3'd2, 32'h0000_000C);
    rd(3'd6, "R5 R7 edge status");

    // R4: write 0 no effect, write 1 clears
    cyc(8'hFF, 8'h00, 1'b1, 3'd4, 32'h0000_0000);
    rd(3'd4, "R4 write zero keeps");
    cyc(8'hFF, 8'h00, 1'b1, 3'd4, 32'h0000_0030);
    rd(3'd4, "R4 rise clear");
    rd(3'd6, "R4 status after clear");

    // R10: edge and clear in the same cycle
    cyc(8'hFE, 8'h00, 1'b1, 3'd5, 32'h0000_0001);
    rd(3'd5, "R10 fall edge beats clear");

    // R8: status write on edge channels
    cyc(8'hFE, 8'h00, 1'b1, 3'd6, 32'h0000_00FF);
    rd(3'd4, "R8 rise cleared");
    rd(3'd5, "R8 fall cleared");

    // R6 R9: level channels
    cyc(8'hFE, 8'h00, 1'b1, 3'd0, 32'h0000_0003);
    cyc(8'hFE, 8'h00, 1'b1, 3'd1, 32'h0000_0003);
    cyc(8'hFE, 8'h00, 1'b1, 3'd3, 32'h0000_0001);
    rd(3'd6, "R6 level status");
    cyc(8'hFE, 8'h00, 1'b1, 3'd6, 32'h0000_0003);
    rd(3'd3, "R9 polarity flipped");
    rd(3'd6, "R9 status after flip");
    cyc(8'hFD, 8'h00, 1'b0, 3'd0, 0);
    rd(3'd6, "R6 level follows pin");

    // R11: pattern select and event bit
    cyc(8'hFD, 8'hA5, 1'b1, 3'd7, 32'hFFFF_FFFF);
    rd(3'd7, "R11 ctrl readback");
    rd(3'd6, "R7 status under pattern select");
    check({24'd0, irq_o}, 32'h0000_00A5, "R11 pattern on irq");
    cyc(8'hFD, 8'h3C, 1'b1, 3'd7, 32'h0000_0002);
    rd(3'd7, "R11 ctrl event only");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      cyc(8'($urandom), 8'($urandom), ($urandom_range(0, 9) < 3), a, $urandom);
      if (n % 3 == 0) rd(3'($urandom_range(0, 7)), "R3/R5/R6/R7 random read");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule